// File: doc/BRIEF.md
# Link Transmit Packet Serializer

This block sits between three system-side transaction channels and a narrow source-synchronous link. The channels carry write, read-request and read-response transactions. Each is a 104-bit packet offered with an access strobe and throttled by a wait output. The block picks one offered packet, captures it, and sends it out as a framed burst of bytes. Two bytes leave per link clock cycle: one lane for the rising edge and one for the falling edge. A double-data-rate output cell outside the block merges the two lanes onto one 8-bit pin group.

The far end can push back on two traffic classes separately. One hold input covers write-class traffic. Read responses travel toward the requester as writes, so that hold covers them too. The other hold input covers read requests. A held class is skipped during selection. A packet that has already started always runs to its end. The read-response channel carries the data that answers read requests received from the far end, and it has the highest priority.

Top module: `lnk_tx_serializer`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted, all three wait outputs are high. After it, link_frame is low and both byte lanes are 0x00.
- R2: Selection is fixed priority: read response above write, and write above read request. Only channels with access high and no matching hold take part. Every channel not selected sees its wait output high.
- R3: link_wr_hold blocks the write and read-response channels, and link_rd_hold blocks the read-request channel. A blocked channel is skipped, so an unblocked lower-priority channel can go ahead. When every requester is blocked, no packet starts.
- R4: A packet is accepted on a rising clock edge where its channel has access high and wait low. While a packet is being sent, all three wait outputs are high.
- R5: link_frame rises in the cycle after acceptance and stays high for exactly 7 consecutive cycles.
- R6: In frame cycle k (k = 0 to 6), the rising lane carries packet bits [103-16k : 96-16k] and the falling lane carries bits [95-16k : 88-16k]. So the bytes go most significant first, and the falling lane in cycle 6 carries the pad byte 0x00. Packet bits [71:40] are the data word and bits [103:72] are the return address or upper data. The block passes these fields through unchanged in that order.
- R7: A hold input raised while a packet is being sent has no effect on that packet. All of its bytes and its frame are sent unchanged.
- R8: Between two packets, link_frame is low for at least one cycle. The earliest next acceptance is at the edge that ends that low cycle.
- R9: The packet is captured at acceptance. Changes on a packet input during transmission have no effect on the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-side core clock |
| rst | input | 1 | Synchronous active-high reset |
| rdrsp_access | input | 1 | Read-response packet offered |
| rdrsp_packet | input | 104 | Read-response packet |
| rdrsp_wait | output | 1 | Read-response pushback |
| wr_access | input | 1 | Write packet offered |
| wr_packet | input | 104 | Write packet |
| wr_wait | output | 1 | Write pushback |
| rdreq_access | input | 1 | Read-request packet offered |
| rdreq_packet | input | 104 | Read-request packet |
| rdreq_wait | output | 1 | Read-request pushback |
| link_wr_hold | input | 1 | Far-end pushback for write-class traffic |
| link_rd_hold | input | 1 | Far-end pushback for read requests |
| link_frame | output | 1 | High while packet bytes are on the lanes |
| link_byte_rise | output | 8 | Byte sent on the rising clock edge |
| link_byte_fall | output | 8 | Byte sent on the falling clock edge |

## Verification
The assertions assume that every input has a defined value from the first clock edge on. They also assume that a system channel keeps its access and packet steady until it sees wait low at a clock edge, and drops access right after that edge. The stimulus sets every input at time zero and changes inputs only on falling clock edges. After each acceptance edge, it deasserts the accepted channel's access before the next rising edge. The hold and packet changes made during transmission fall inside this contract, because wait is already high for every channel at that point.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;

  // Channel slots, listed in falling priority order.
  localparam int NUM_CH    = 3;
  localparam int IDX_RDRSP = 0;
  localparam int IDX_WR    = 1;
  localparam int IDX_RDREQ = 2;

  // Number of bytes needed for a packet of pkt_w bits on a lane_w lane.
  function automatic int unsigned bytes_for(input int unsigned pkt_w, input int unsigned lane_w);
    return (pkt_w + lane_w - 1) / lane_w;
  endfunction

  // Link clock cycles per packet when two bytes move per cycle.
  function automatic int unsigned beats_for(input int unsigned pkt_w, input int unsigned lane_w);
    return (bytes_for(pkt_w, lane_w) + 1) / 2;
  endfunction

  // Counter width that holds values 0 .. n-1, never less than one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lnk_tx_arb.sv
module lnk_tx_arb #(
  parameter int NUM_CH = 3
) (
  input  logic              en,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] hold,
  output logic [NUM_CH-1:0] gnt
);

  logic [NUM_CH-1:0] elig;
  assign elig = req & ~hold;

  // Slot 0 wins outright; every later slot needs all earlier slots idle.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign gnt[i] = en & elig[i];
    end else begin : g_low
      assign gnt[i] = en & elig[i] & ~(|elig[i-1:0]);
    end
  end

endmodule

// File: rtl/lnk_tx_seq.sv
module lnk_tx_seq
  import lnk_tx_pkg::*;
#(
  parameter int PKT_W  = 104,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PKT_W-1:0]  load_data,
  output logic              busy,
  output logic              last_beat,
  output logic [LANE_W-1:0] byte_rise,
  output logic [LANE_W-1:0] byte_fall
);

  localparam int NBEATS  = int'(beats_for(PKT_W, LANE_W));
  localparam int CNT_W   = int'(cnt_width(NBEATS));
  localparam int STEP_W  = 2 * LANE_W;
  localparam int SHIFT_W = NBEATS * STEP_W;

  logic [SHIFT_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;
  logic [SHIFT_W-1:0] load_vec;

  // Packet left-aligned in the shifter; any pad bits below it are zero.
  always_comb begin
    load_vec = '0;
    load_vec[SHIFT_W-1 -: PKT_W] = load_data;
  end

  assign busy      = busy_q;
  assign last_beat = busy_q && (cnt_q == CNT_W'(NBEATS - 1));
  assign byte_rise = sh_q[SHIFT_W-1 -: LANE_W];
  assign byte_fall = sh_q[SHIFT_W-LANE_W-1 -: LANE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        sh_q   <= load_vec;
      end
    end else if (last_beat) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= sh_q << STEP_W;
    end
  end

  // Independent count of frame cycles for the length check.
  logic [CNT_W:0] frame_len_q;
  always_ff @(posedge clk) begin
    if (rst)         frame_len_q <= '0;
    else if (busy_q) frame_len_q <= frame_len_q + 1'b1;
    else             frame_len_q <= '0;
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst) start |-> !busy_q); // R4
  AST_START_FRAME: assert property (@(posedge clk) disable iff (rst) (start && !busy_q) |=> busy_q); // R5
  AST_FRAME_MAX: assert property (@(posedge clk) disable iff (rst) busy_q |-> (frame_len_q < (CNT_W+1)'(NBEATS))); // R5
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst) $fell(busy_q) |-> ($past(frame_len_q) == (CNT_W+1)'(NBEATS - 1))); // R5
  AST_FRAME_GAP: assert property (@(posedge clk) disable iff (rst) last_beat |=> !busy_q); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !busy_q |-> (byte_rise == '0 && byte_fall == '0)); // R1

endmodule

// File: rtl/lnk_tx_serializer.sv
module lnk_tx_serializer
  import lnk_tx_pkg::*;
#(
  parameter int PKT_W  = 104,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdrsp_access,
  input  logic [PKT_W-1:0]  rdrsp_packet,
  output logic              rdrsp_wait,
  input  logic              wr_access,
  input  logic [PKT_W-1:0]  wr_packet,
  output logic              wr_wait,
  input  logic              rdreq_access,
  input  logic [PKT_W-1:0]  rdreq_packet,
  output logic              rdreq_wait,
  input  logic              link_wr_hold,
  input  logic              link_rd_hold,
  output logic              link_frame,
  output logic [LANE_W-1:0] link_byte_rise,
  output logic [LANE_W-1:0] link_byte_fall
);

  logic [NUM_CH-1:0] req;
  logic [NUM_CH-1:0] hold;
  logic [NUM_CH-1:0] gnt;
  logic [PKT_W-1:0]  pkts [NUM_CH];
  logic [PKT_W-1:0]  sel_pkt;
  logic              busy;
  logic              last_beat;
  logic              arb_en;
  logic              accept;

  assign req[IDX_RDRSP]  = rdrsp_access;
  assign req[IDX_WR]     = wr_access;
  assign req[IDX_RDREQ]  = rdreq_access;
  assign pkts[IDX_RDRSP] = rdrsp_packet;
  assign pkts[IDX_WR]    = wr_packet;
  assign pkts[IDX_RDREQ] = rdreq_packet;

  // Read responses travel as write-class traffic on the link.
  assign hold[IDX_RDRSP] = link_wr_hold;
  assign hold[IDX_WR]    = link_wr_hold;
  assign hold[IDX_RDREQ] = link_rd_hold;

  assign arb_en = !busy && !rst;

  lnk_tx_arb #(.NUM_CH(NUM_CH)) u_arb (
    .en   (arb_en),
    .req  (req),
    .hold (hold),
    .gnt  (gnt)
  );

  assign accept = |gnt;

  always_comb begin
    sel_pkt = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (gnt[i]) sel_pkt = sel_pkt | pkts[i];
    end
  end

  assign rdrsp_wait = rst | ~gnt[IDX_RDRSP];
  assign wr_wait    = rst | ~gnt[IDX_WR];
  assign rdreq_wait = rst | ~gnt[IDX_RDREQ];

  lnk_tx_seq #(.PKT_W(PKT_W), .LANE_W(LANE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .load_data (sel_pkt),
    .busy      (busy),
    .last_beat (last_beat),
    .byte_rise (link_byte_rise),
    .byte_fall (link_byte_fall)
  );

  assign link_frame = busy;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0({rdrsp_wait, wr_wait, rdreq_wait} ^ 3'b111)); // R2
  AST_WR_BELOW_RSP: assert property (@(posedge clk) disable iff (rst) !wr_wait |-> !(rdrsp_access && !link_wr_hold)); // R2
  AST_REQ_LOWEST: assert property (@(posedge clk) disable iff (rst) !rdreq_wait |-> !((rdrsp_access || wr_access) && !link_wr_hold)); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst) link_wr_hold |-> (wr_wait && rdrsp_wait)); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) link_rd_hold |-> rdreq_wait); // R3
  AST_BUSY_WAIT: assert property (@(posedge clk) disable iff (rst) link_frame |-> (rdrsp_wait && wr_wait && rdreq_wait)); // R4
  AST_ACCEPT_FRAME: assert property (@(posedge clk) disable iff (rst) (!link_frame && (!rdrsp_wait || !wr_wait || !rdreq_wait)) |=> link_frame); // R5
  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (rst) (link_frame && !last_beat) |=> link_frame); // R7

endmodule

// File: tb/lnk_tx_serializer_test.sv
module lnk_tx_serializer_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rdrsp_access = 1'b0, wr_access = 1'b0, rdreq_access = 1'b0;
  logic [103:0] rdrsp_packet = '0, wr_packet = '0, rdreq_packet = '0;
  logic         rdrsp_wait, wr_wait, rdreq_wait;
  logic         link_wr_hold = 1'b0, link_rd_hold = 1'b0;
  logic         link_frame;
  logic [7:0]   link_byte_rise, link_byte_fall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lnk_tx_serializer uut (
    .clk(clk), .rst(rst),
    .rdrsp_access(rdrsp_access), .rdrsp_packet(rdrsp_packet), .rdrsp_wait(rdrsp_wait),
    .wr_access(wr_access), .wr_packet(wr_packet), .wr_wait(wr_wait),
    .rdreq_access(rdreq_access), .rdreq_packet(rdreq_packet), .rdreq_wait(rdreq_wait),
    .link_wr_hold(link_wr_hold), .link_rd_hold(link_rd_hold),
    .link_frame(link_frame), .link_byte_rise(link_byte_rise), .link_byte_fall(link_byte_fall)
  );

  task automatic chk(input string what, input logic [103:0] act, input logic [103:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Rising lane in frame cycle k: bits [103-16k : 96-16k].
  function automatic logic [7:0] want_rise(input logic [103:0] p, input int k);
    logic [103:0] s;
    s = p >> (96 - 16 * k);
    return s[7:0];
  endfunction

  // Falling lane in frame cycle k: bits [95-16k : 88-16k]; the final one is pad.
  function automatic logic [7:0] want_fall(input logic [103:0] p, input int k);
    logic [103:0] s;
    if (k == 6) return 8'h00;
    s = p >> (88 - 16 * k);
    return s[7:0];
  endfunction

  // Called at the falling edge just after acceptance; returns at the gap cycle.
  task automatic expect_packet(input string tag, input logic [103:0] p);
    for (int k = 0; k < 7; k++) begin
      if (k > 0) @(negedge clk);
      chk($sformatf("%s R5 frame beat %0d", tag, k), link_frame, 1'b1);
      chk($sformatf("%s R6 rise beat %0d", tag, k), link_byte_rise, want_rise(p, k));
      chk($sformatf("%s R6 fall beat %0d", tag, k), link_byte_fall, want_fall(p, k));
    end
    @(negedge clk);
    chk({tag, " R8 frame low after packet"}, link_frame, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    rdrsp_access = 1'b1; wr_access = 1'b1; rdreq_access = 1'b1;
    @(negedge clk); @(negedge clk);
    #1;
    chk("R1 waits high in reset", {rdrsp_wait, wr_wait, rdreq_wait}, 3'b111);
    chk("R1 frame low in reset", link_frame, 1'b0);
    chk("R1 lanes zero in reset", {link_byte_rise, link_byte_fall}, 16'h0000);
    rdrsp_access = 1'b0; wr_access = 1'b0; rdreq_access = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 frame low after reset", link_frame, 1'b0);
    chk("R1 lanes zero after reset", {link_byte_rise, link_byte_fall}, 16'h0000);
  endtask

  task automatic t_single_write;
    logic [103:0] p;
    p = 104'h0102030405060708090A0B0C0D;
    wr_packet = p; wr_access = 1'b1;
    #1;
    chk("R4 write wait low when offered", wr_wait, 1'b0);
    @(negedge clk);
    wr_access = 1'b0;
    #1;
    chk("R4 waits high while busy", {rdrsp_wait, wr_wait, rdreq_wait}, 3'b111);
    expect_packet("single write", p);
  endtask

  task automatic t_priority;
    logic [103:0] a, b, c;
    a = 104'hA1A2A3A4_A5A6A7A8_A9AAABACAD;
    b = 104'hB0B1B2B3_DEADBEEF_1234567855;
    c = 104'hC0FFEE00_11223344_5566778899;
    @(negedge clk);
    rdrsp_packet = a; wr_packet = b; rdreq_packet = c;
    rdrsp_access = 1'b1; wr_access = 1'b1; rdreq_access = 1'b1;
    #1;
    chk("R2 read response wins", {rdrsp_wait, wr_wait, rdreq_wait}, 3'b011);
    @(negedge clk);
    rdrsp_access = 1'b0;
    #1;
    chk("R4 all waits high while sending", {rdrsp_wait, wr_wait, rdreq_wait}, 3'b111);
    expect_packet("priority rdrsp", a);
    #1;
    chk("R2 write next in gap cycle", {rdrsp_wait, wr_wait, rdreq_wait}, 3'b101);
    @(negedge clk);
    wr_access = 1'b0;
    expect_packet("priority wr", b);
    #1;
    chk("R2 read request last", {rdrsp_wait, wr_wait, rdreq_wait}, 3'b110);
    @(negedge clk);
    rdreq_access = 1'b0;
    expect_packet("priority rdreq", c);
  endtask

  task automatic t_holds;
    logic [103:0] c, a;
    c = 104'h00FF00FF_00FF00FF_00FF00FF00;
    a = 104'h5A5A5A5A_A5A5A5A5_3C3C3C3CC3;
    @(negedge clk);
    link_wr_hold = 1'b1;
    rdrsp_packet = a; rdreq_packet = c; wr_packet = 104'h1;
    rdrsp_access = 1'b1; wr_access = 1'b1; rdreq_access = 1'b1;
    #1;
    chk("R3 write hold skips to read request", {rdrsp_wait, wr_wait, rdreq_wait}, 3'b110);
    @(negedge clk);
    rdreq_access = 1'b0;
    expect_packet("hold rdreq", c);
    link_rd_hold = 1'b1;
    rdreq_access = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 all blocked no frame", link_frame, 1'b0);
    chk("R3 all blocked waits high", {rdrsp_wait, wr_wait, rdreq_wait}, 3'b111);
    link_wr_hold = 1'b0;
    #1;
    chk("R3 release lets read response go", {rdrsp_wait, wr_wait, rdreq_wait}, 3'b011);
    @(negedge clk);
    rdrsp_access = 1'b0;
    expect_packet("hold release rdrsp", a);
    wr_access = 1'b0; rdreq_access = 1'b0; link_rd_hold = 1'b0;
  endtask

  task automatic t_mid_packet;
    logic [103:0] q;
    q = 104'h13579BDF_2468ACE0_FEDCBA9876;
    @(negedge clk);
    wr_packet = q; wr_access = 1'b1;
    @(negedge clk);
    wr_access = 1'b0;
    link_wr_hold = 1'b1;
    wr_packet = ~q;
    expect_packet("R7 R9 hold and packet change ignored", q);
    link_wr_hold = 1'b0;
  endtask

  initial begin
    t_reset();
    t_single_write();
    t_priority();
    t_holds();
    t_mid_packet();
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule